// File: doc/BRIEF.md
# ECC Error Logging and Capture Unit

This block sits beside the read path of a memory controller that protects each 64-bit beat with a single-error-correct, double-error-detect code. On every returned beat it receives the decoder's verdict as a two-bit class, a chip-select-miss flag, and the beat's address, data, check byte and transaction attributes. From these it keeps sticky error flags, counts correctable errors against a software threshold, and freezes a snapshot of the first reportable error. It raises one interrupt line under per-class enables.

Software reaches the unit through a word-addressed register port with byte strobes. The port supports plain masked writes, write-one-to-clear on the status word, and zero-writes that empty the snapshot so a new one can be taken. A per-class disable stops a class before it can touch any flag, counter or snapshot. Reads are combinational and have no side effects.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: A multi-bit beat (class 2) sets status bit 1, and a beat with `rd_cs_miss` high sets status bit 2, one cycle later and without changing the correctable-error counter; class 0 and class 3 report nothing.
- R3: Each enabled class-1 beat adds one to the counter (word 3, bits 7:0), which saturates at 255; when the new value equals a nonzero threshold (word 3, bits 15:8), status bit 0 is set, the beat is captured and the counter returns to 0.
- R4: With a threshold of 0 every enabled class-1 beat sets status bit 0 and the counter still counts.
- R5: Disable word 1 (bit 0 correctable, bit 1 multi-bit, bit 2 select miss) stops the class from setting a flag, counting or capturing.
- R6: The first reportable error, while the valid bit (word 8 bit 31) is clear, loads word 4 with the address, word 5 with data bits 63:32, word 6 with data bits 31:0, word 7 with the check byte, and word 8 with beat number at bits 2:0, size at 6:4, source at 12:8, type at 17:16 and valid = 1.
- R7: A reportable error while valid is set sets status bit 3 and leaves words 4 to 8 unchanged.
- R8: Writing 1 to a status bit (0 single, 1 multi, 2 select, 3 repeated) clears it and writing 0 leaves it; a set in the same cycle wins over the clear.
- R9: Byte strobe 0 writes only the counter and strobe 1 only the threshold, each without disturbing the other.
- R10: Writing zero to words 4 to 8 clears them, valid included, and the next reportable error is captured again.
- R11: `irq` is high exactly when a status bit among 0 to 2 is set whose enable in word 2 (same bit order as word 1) is set; bit 3 never drives it.
- R12: Unimplemented bits and unmapped word addresses read 0, even after writing ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | A read beat's check result is present |
| rd_class | input | 2 | 0 clean, 1 corrected single bit, 2 uncorrectable, 3 treated as clean |
| rd_cs_miss | input | 1 | The beat's address matched no chip select |
| rd_addr | input | ADDR_W | Beat address |
| rd_data | input | 64 | Raw beat data |
| rd_chk | input | CHK_W | Raw check byte |
| rd_beat | input | BEAT_W | Beat number in the burst |
| rd_size | input | SIZE_W | Transaction size code |
| rd_src | input | SRC_W | Transaction source id |
| rd_type | input | TYPE_W | Transaction type code |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wstrb | input | 4 | Byte lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Error interrupt |

## Verification
The assertions take it that a beat's class, miss flag and payload are steady around the rising edge while `rd_valid` is high, and that software does not write a snapshot word in the same cycle a new error is being captured; the snapshot-hold property excludes such cycles explicitly. The stimulus changes every input on the falling edge, presents each beat for exactly one cycle, and never overlaps a snapshot write with a beat. The only deliberate overlap is a status clear meeting a new multi-bit error, which is the case the set-over-clear rule covers.

// File: rtl/ecc_log_pkg.sv
// Package: shared constants, register map and helper functions for the
// ECC error logging unit. Assumes a 32-bit register word.
package ecc_log_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned RA_W  = 4;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_MULTI  = 2'd2,
        CLS_RSVD   = 2'd3
    } ecc_class_e;

    // Register word addresses
    localparam logic [RA_W-1:0] RA_STATUS   = 4'd0;
    localparam logic [RA_W-1:0] RA_DISABLE  = 4'd1;
    localparam logic [RA_W-1:0] RA_IRQ_EN   = 4'd2;
    localparam logic [RA_W-1:0] RA_SBE      = 4'd3;
    localparam int unsigned     RA_CAP_BASE = 4;
    localparam int unsigned     NUM_CAP     = 5;

    // Status / enable bit positions
    localparam int unsigned FLG_SBE  = 0;
    localparam int unsigned FLG_MBE  = 1;
    localparam int unsigned FLG_MSE  = 2;
    localparam int unsigned FLG_MANY = 3;

    // Attribute word field positions
    localparam int unsigned ATTR_BEAT_LSB  = 0;
    localparam int unsigned ATTR_SIZE_LSB  = 4;
    localparam int unsigned ATTR_SRC_LSB   = 8;
    localparam int unsigned ATTR_TYPE_LSB  = 16;
    localparam int unsigned ATTR_VALID_BIT = 31;

    // Threshold field offset inside the counter word
    localparam int unsigned THR_LSB = 8;

    // Mask with the n low bits set.
    function automatic logic [REG_W-1:0] low_ones(input int unsigned n);
        logic [REG_W-1:0] r;
        for (int i = 0; i < REG_W; i++) r[i] = (i < n);
        return r;
    endfunction

    // Expand byte strobes into a bit mask.
    function automatic logic [REG_W-1:0] strobe_mask(input logic [REG_W/8-1:0] s);
        logic [REG_W-1:0] r;
        for (int b = 0; b < REG_W/8; b++) r[b*8 +: 8] = {8{s[b]}};
        return r;
    endfunction

endpackage

// File: rtl/ecc_sbe_tracker.sv
// Correctable-error counter with a programmable threshold.
// Assumes: hit is already qualified by the class disable. Bus writes to
// either field take priority over the increment in the same cycle.
module ecc_sbe_tracker #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             wr_cnt,
    input  logic             wr_thr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] thr_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] thr_q,
    output logic             report
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_inc;
    logic             at_thr;

    // Saturating increment and threshold comparison
    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
        at_thr  = (thr_q != '0) && (cnt_inc == thr_q);
        report  = hit && ((thr_q == '0) || at_thr);
    end

    // Threshold register
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= '0;
        else if (wr_thr) thr_q <= thr_wdata;
    end

    // Counter: bus write, else count and wrap to 0 at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= cnt_wdata;
        else if (hit)    cnt_q <= at_thr ? '0 : cnt_inc;
    end

endmodule

// File: rtl/ecc_capture_bank.sv
// Bank of snapshot words. Each word takes a masked bus write with priority
// over a hardware load; bits outside IMPL_MASK always stay 0.
module ecc_capture_bank #(
    parameter int unsigned                      REG_W     = 32,
    parameter int unsigned                      NUM_WORDS = 5,
    parameter logic [NUM_WORDS*REG_W-1:0]       IMPL_MASK = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NUM_WORDS-1:0]       wr_sel,
    input  logic [REG_W-1:0]           wr_mask,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [NUM_WORDS*REG_W-1:0] load_data,
    output logic [NUM_WORDS*REG_W-1:0] words_q
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [REG_W-1:0] IMPL = IMPL_MASK[i*REG_W +: REG_W];
        logic [REG_W-1:0] word_q;

        // One snapshot word: bus write first, then hardware capture
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_sel[i])
                word_q <= ((word_q & ~wr_mask) | (wr_data & wr_mask)) & IMPL;
            else if (load)
                word_q <= load_data[i*REG_W +: REG_W] & IMPL;
        end

        assign words_q[i*REG_W +: REG_W] = word_q;
    end

endmodule

// File: rtl/ecc_err_log.sv
// ECC error logging and capture unit: qualifies each read beat's check
// result, keeps sticky flags, counts correctable errors, snapshots the
// first reportable error and drives an interrupt.
// Assumes: one beat per cycle at most; CNT_W <= 8; ADDR_W <= 32.
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CHK_W  = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned BEAT_W = 3,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned SRC_W  = 5,
    parameter int unsigned TYPE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [1:0]        rd_class,
    input  logic              rd_cs_miss,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [63:0]       rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    input  logic [BEAT_W-1:0] rd_beat,
    input  logic [SIZE_W-1:0] rd_size,
    input  logic [SRC_W-1:0]  rd_src,
    input  logic [TYPE_W-1:0] rd_type,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [3:0]        reg_wstrb,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam logic [REG_W-1:0] ATTR_MASK =
        (low_ones(BEAT_W) << ATTR_BEAT_LSB) | (low_ones(SIZE_W) << ATTR_SIZE_LSB) |
        (low_ones(SRC_W)  << ATTR_SRC_LSB)  | (low_ones(TYPE_W) << ATTR_TYPE_LSB) |
        (low_ones(1)      << ATTR_VALID_BIT);
    localparam logic [NUM_CAP*REG_W-1:0] CAP_IMPL =
        {ATTR_MASK, low_ones(CHK_W), {REG_W{1'b1}}, {REG_W{1'b1}}, low_ones(ADDR_W)};

    logic [3:0]               flags_q;
    logic [2:0]               dis_q, ien_q;
    logic [REG_W-1:0]         wmask;
    logic                     wr_status, wr_dis, wr_ien, wr_sbe;
    logic [NUM_CAP-1:0]       cap_wr_sel;
    logic                     cap_wr_any;
    logic                     sbe_hit, mbe_hit, mse_hit, sbe_report;
    logic                     report_any, cap_valid, cap_load;
    logic [CNT_W-1:0]         sbe_cnt, sbe_thr;
    logic [NUM_CAP*REG_W-1:0] cap_words, cap_new;
    logic [REG_W-1:0]         attr_new, addr_new;
    logic [3:0]               flag_set, flag_clr;

    // Register write decode
    always_comb begin
        wmask     = strobe_mask(reg_wstrb);
        wr_status = reg_wr && (reg_addr == RA_STATUS);
        wr_dis    = reg_wr && (reg_addr == RA_DISABLE);
        wr_ien    = reg_wr && (reg_addr == RA_IRQ_EN);
        wr_sbe    = reg_wr && (reg_addr == RA_SBE);
        for (int i = 0; i < NUM_CAP; i++)
            cap_wr_sel[i] = reg_wr && (reg_addr == RA_W'(RA_CAP_BASE + i));
        cap_wr_any = |cap_wr_sel;
    end

    // Error qualification by class disables
    always_comb begin
        sbe_hit = rd_valid && (rd_class == CLS_SINGLE) && !dis_q[FLG_SBE];
        mbe_hit = rd_valid && (rd_class == CLS_MULTI)  && !dis_q[FLG_MBE];
        mse_hit = rd_valid && rd_cs_miss               && !dis_q[FLG_MSE];
    end

    ecc_sbe_tracker #(.CNT_W(CNT_W)) u_sbe (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (sbe_hit),
        .wr_cnt    (wr_sbe && reg_wstrb[0]),
        .wr_thr    (wr_sbe && reg_wstrb[1]),
        .cnt_wdata (reg_wdata[CNT_W-1:0]),
        .thr_wdata (reg_wdata[THR_LSB +: CNT_W]),
        .cnt_q     (sbe_cnt),
        .thr_q     (sbe_thr),
        .report    (sbe_report)
    );

    // Snapshot payload assembly and load condition
    always_comb begin
        report_any = sbe_report || mbe_hit || mse_hit;
        cap_valid  = cap_words[(NUM_CAP-1)*REG_W + ATTR_VALID_BIT];
        cap_load   = report_any && !cap_valid;
        addr_new   = '0;
        addr_new[ADDR_W-1:0] = rd_addr;
        attr_new   = '0;
        attr_new[ATTR_BEAT_LSB +: BEAT_W] = rd_beat;
        attr_new[ATTR_SIZE_LSB +: SIZE_W] = rd_size;
        attr_new[ATTR_SRC_LSB  +: SRC_W]  = rd_src;
        attr_new[ATTR_TYPE_LSB +: TYPE_W] = rd_type;
        attr_new[ATTR_VALID_BIT]          = 1'b1;
        cap_new = {attr_new, REG_W'(rd_chk), rd_data[31:0], rd_data[63:32], addr_new};
    end

    ecc_capture_bank #(
        .REG_W     (REG_W),
        .NUM_WORDS (NUM_CAP),
        .IMPL_MASK (CAP_IMPL)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap_load),
        .wr_sel    (cap_wr_sel),
        .wr_mask   (wmask),
        .wr_data   (reg_wdata),
        .load_data (cap_new),
        .words_q   (cap_words)
    );

    // Sticky flag set/clear vectors; a set wins over a clear
    always_comb begin
        flag_set = '0;
        flag_set[FLG_SBE]  = sbe_report;
        flag_set[FLG_MBE]  = mbe_hit;
        flag_set[FLG_MSE]  = mse_hit;
        flag_set[FLG_MANY] = report_any && cap_valid;
        flag_clr = wr_status ? (reg_wdata[3:0] & wmask[3:0]) : 4'b0;
    end

    // Status, disable and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            dis_q   <= '0;
            ien_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | flag_set;
            if (wr_dis) dis_q <= (dis_q & ~wmask[2:0]) | (reg_wdata[2:0] & wmask[2:0]);
            if (wr_ien) ien_q <= (ien_q & ~wmask[2:0]) | (reg_wdata[2:0] & wmask[2:0]);
        end
    end

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_STATUS:  reg_rdata[3:0] = flags_q;
            RA_DISABLE: reg_rdata[2:0] = dis_q;
            RA_IRQ_EN:  reg_rdata[2:0] = ien_q;
            RA_SBE: begin
                reg_rdata[CNT_W-1:0]       = sbe_cnt;
                reg_rdata[THR_LSB +: CNT_W] = sbe_thr;
            end
            default: begin
                for (int i = 0; i < NUM_CAP; i++)
                    if (reg_addr == RA_W'(RA_CAP_BASE + i))
                        reg_rdata = cap_words[i*REG_W +: REG_W];
            end
        endcase
    end

    // Interrupt from enabled detect flags
    assign irq = |(flags_q[2:0] & ien_q);

endmodule

// File: rtl/ecc_err_log_chk.sv
// Property checker for ecc_err_log, attached by bind below. Observes beat
// inputs, register decode and state; drives nothing.
module ecc_err_log_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic [1:0]       rd_class,
    input logic             rd_cs_miss,
    input logic [2:0]       dis_q,
    input logic [3:0]       flags_q,
    input logic [CNT_W-1:0] sbe_cnt,
    input logic             wr_sbe,
    input logic             cap_valid,
    input logic             cap_wr_any,
    input logic             report_any,
    input logic [159:0]     cap_words,
    input logic             irq
);
    // R2: uncorrectable beat sets its flag next cycle
    a_r2_mbe_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_class == 2'd2 && !dis_q[1]) |=> flags_q[1]);

    // R2: select miss sets its flag next cycle
    a_r2_mse_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_cs_miss && !dis_q[2]) |=> flags_q[2]);

    // R5: disabled correctable class does not count
    a_r5_sbe_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_class == 2'd1 && dis_q[0] && !wr_sbe) |=> $stable(sbe_cnt));

    // R6: a reportable error with an empty snapshot makes it valid
    a_r6_capture_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (report_any && !cap_valid && !cap_wr_any) |=> cap_valid);

    // R7: an error onto a held snapshot raises the repeat flag
    a_r7_many_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (report_any && cap_valid) |=> flags_q[3]);

    // R7: a held snapshot is not overwritten by hardware
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_wr_any) |=> $stable(cap_words));

    // R11: no interrupt without a class flag
    a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[2:0] == 3'b000) |-> !irq);

endmodule

bind ecc_err_log ecc_err_log_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_class   (rd_class),
    .rd_cs_miss (rd_cs_miss),
    .dis_q      (dis_q),
    .flags_q    (flags_q),
    .sbe_cnt    (sbe_cnt),
    .wr_sbe     (wr_sbe),
    .cap_valid  (cap_valid),
    .cap_wr_any (cap_wr_any),
    .report_any (report_any),
    .cap_words  (cap_words),
    .irq        (irq)
);

// File: tb/test_ecc_err_log.sv
`timescale 1ns/1ps
module test_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [1:0]  rd_class = '0;
    logic        rd_cs_miss = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_chk = '0;
    logic [2:0]  rd_beat = '0;
    logic [2:0]  rd_size = '0;
    logic [4:0]  rd_src = '0;
    logic [1:0]  rd_type = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_wstrb = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ecc_err_log i_ecc_err_log (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_class(rd_class),
        .rd_cs_miss(rd_cs_miss), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_chk(rd_chk), .rd_beat(rd_beat), .rd_size(rd_size), .rd_src(rd_src),
        .rd_type(rd_type), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wstrb = s; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        reg_read(a, d);
        check(req, d, exp);
    endtask

    task automatic beat(input logic [1:0] cls, input logic miss, input logic [31:0] a,
                        input logic [63:0] d, input logic [7:0] c, input logic [2:0] bn,
                        input logic [2:0] sz, input logic [4:0] src, input logic [1:0] ty);
        @(negedge clk);
        rd_valid = 1'b1; rd_class = cls; rd_cs_miss = miss; rd_addr = a; rd_data = d;
        rd_chk = c; rd_beat = bn; rd_size = sz; rd_src = src; rd_type = ty;
        @(negedge clk);
        rd_valid = 1'b0; rd_class = '0; rd_cs_miss = 1'b0;
    endtask

    task automatic simple_beat(input logic [1:0] cls, input logic miss, input logic [31:0] a);
        beat(cls, miss, a, 64'h0, 8'h0, 3'd0, 3'd0, 5'd0, 2'd0);
    endtask

    task automatic cleanup();
        for (int i = 4; i <= 8; i++) reg_write(4'(i), 32'h0, 4'hF);
        reg_write(4'd1, 32'h0, 4'hF);
        reg_write(4'd2, 32'h0, 4'hF);
        reg_write(4'd3, 32'h0, 4'hF);
        reg_write(4'd0, 32'hF, 4'hF);
    endtask

    task automatic t_reset();
        for (int i = 0; i <= 8; i++) expect_reg("R1 reset value", 4'(i), 32'h0);
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_strobe();
        reg_write(4'd3, 32'h0000_0507, 4'hF);
        expect_reg("R9 full write", 4'd3, 32'h0000_0507);
        reg_write(4'd3, 32'h0000_0900, 4'h2);
        expect_reg("R9 threshold only", 4'd3, 32'h0000_0907);
        reg_write(4'd3, 32'h0000_0004, 4'h1);
        expect_reg("R9 counter only", 4'd3, 32'h0000_0904);
        reg_write(4'd1, 32'hFFFF_FFFF, 4'hF);
        expect_reg("R12 disable unused bits", 4'd1, 32'h0000_0007);
        reg_write(4'd8, 32'hFFFF_FFFF, 4'hF);
        expect_reg("R12 attribute unused bits", 4'd8, 32'h8003_1F77);
        reg_write(4'd13, 32'hFFFF_FFFF, 4'hF);
        expect_reg("R12 unmapped address", 4'd13, 32'h0);
        cleanup();
    endtask

    task automatic t_capture();
        beat(2'd2, 1'b0, 32'h1234_5678, 64'hFEDC_BA98_7654_3210, 8'hA5, 3'd5, 3'd3, 5'h11, 2'd2);
        expect_reg("R6 address", 4'd4, 32'h1234_5678);
        expect_reg("R6 data high", 4'd5, 32'hFEDC_BA98);
        expect_reg("R6 data low", 4'd6, 32'h7654_3210);
        expect_reg("R6 check byte", 4'd7, 32'h0000_00A5);
        expect_reg("R6 attributes", 4'd8, 32'h8002_1135);
    endtask

    task automatic t_many();
        beat(2'd2, 1'b0, 32'h0000_BEEF, 64'h1, 8'h3C, 3'd1, 3'd1, 5'h2, 2'd1);
        expect_reg("R7 repeat flag", 4'd0, 32'h0000_000A);
        expect_reg("R7 address kept", 4'd4, 32'h1234_5678);
        expect_reg("R7 check byte kept", 4'd7, 32'h0000_00A5);
    endtask

    task automatic t_clear_capture();
        for (int i = 4; i <= 8; i++) reg_write(4'(i), 32'h0, 4'hF);
        expect_reg("R10 attributes cleared", 4'd8, 32'h0);
        expect_reg("R10 address cleared", 4'd4, 32'h0);
        simple_beat(2'd2, 1'b0, 32'hCAFE_0000);
        expect_reg("R10 recapture address", 4'd4, 32'hCAFE_0000);
        expect_reg("R10 recapture valid", 4'd8, 32'h8000_0000);
        cleanup();
    endtask

    task automatic t_mbe_mse();
        simple_beat(2'd0, 1'b1, 32'h10);
        expect_reg("R2 select miss flag", 4'd0, 32'h0000_0004);
        simple_beat(2'd2, 1'b0, 32'h20);
        expect_reg("R2 multi-bit flag", 4'd0, 32'h0000_000E);
        expect_reg("R2 counter untouched", 4'd3, 32'h0);
        simple_beat(2'd3, 1'b0, 32'h30);
        expect_reg("R2 class 3 ignored", 4'd0, 32'h0000_000E);
        cleanup();
    endtask

    task automatic t_threshold();
        reg_write(4'd3, 32'h0000_0300, 4'h3);
        simple_beat(2'd1, 1'b0, 32'h40);
        simple_beat(2'd1, 1'b0, 32'h48);
        expect_reg("R3 counting below threshold", 4'd3, 32'h0000_0302);
        expect_reg("R3 no flag below threshold", 4'd0, 32'h0);
        simple_beat(2'd1, 1'b0, 32'h50);
        expect_reg("R3 flag at threshold", 4'd0, 32'h0000_0001);
        expect_reg("R3 counter wraps", 4'd3, 32'h0000_0300);
        expect_reg("R3 captured at threshold", 4'd4, 32'h0000_0050);
        cleanup();
        reg_write(4'd3, 32'h0000_03FE, 4'h3);
        simple_beat(2'd1, 1'b0, 32'h60);
        expect_reg("R3 reach 255", 4'd3, 32'h0000_03FF);
        simple_beat(2'd1, 1'b0, 32'h68);
        expect_reg("R3 saturate at 255", 4'd3, 32'h0000_03FF);
        expect_reg("R3 no flag when saturated", 4'd0, 32'h0);
        cleanup();
    endtask

    task automatic t_thr_zero();
        simple_beat(2'd1, 1'b0, 32'h70);
        expect_reg("R4 flag with zero threshold", 4'd0, 32'h0000_0001);
        expect_reg("R4 counter counts", 4'd3, 32'h0000_0001);
        simple_beat(2'd1, 1'b0, 32'h78);
        expect_reg("R4 second report", 4'd0, 32'h0000_0009);
        expect_reg("R4 counter two", 4'd3, 32'h0000_0002);
        cleanup();
    endtask

    task automatic t_disable();
        reg_write(4'd1, 32'h7, 4'hF);
        simple_beat(2'd1, 1'b0, 32'h80);
        simple_beat(2'd2, 1'b0, 32'h88);
        simple_beat(2'd0, 1'b1, 32'h90);
        expect_reg("R5 no flags when disabled", 4'd0, 32'h0);
        expect_reg("R5 no count when disabled", 4'd3, 32'h0);
        expect_reg("R5 no capture when disabled", 4'd8, 32'h0);
        reg_write(4'd1, 32'h6, 4'hF);
        simple_beat(2'd2, 1'b1, 32'h98);
        expect_reg("R5 other classes still off", 4'd0, 32'h0);
        simple_beat(2'd1, 1'b0, 32'hA0);
        expect_reg("R5 re-enabled class reports", 4'd0, 32'h0000_0001);
        cleanup();
    endtask

    task automatic t_w1c();
        simple_beat(2'd2, 1'b1, 32'hB0);
        expect_reg("R8 both flags", 4'd0, 32'h0000_0006);
        reg_write(4'd0, 32'h4, 4'hF);
        expect_reg("R8 clear one", 4'd0, 32'h0000_0002);
        reg_write(4'd0, 32'h0, 4'hF);
        expect_reg("R8 zero write keeps", 4'd0, 32'h0000_0002);
        @(negedge clk);
        reg_addr = 4'd0; reg_wdata = 32'h2; reg_wstrb = 4'hF; reg_wr = 1'b1;
        rd_valid = 1'b1; rd_class = 2'd2;
        @(negedge clk);
        reg_wr = 1'b0; rd_valid = 1'b0; rd_class = 2'd0;
        expect_reg("R8 set wins over clear", 4'd0, 32'h0000_000A);
        cleanup();
    endtask

    task automatic t_irq();
        reg_write(4'd2, 32'h2, 4'hF);
        simple_beat(2'd0, 1'b1, 32'hC0);
        check("R11 disabled class no irq", {31'b0, irq}, 32'h0);
        simple_beat(2'd2, 1'b0, 32'hC8);
        check("R11 enabled class irq", {31'b0, irq}, 32'h1);
        reg_write(4'd0, 32'h2, 4'hF);
        check("R11 irq drops on clear", {31'b0, irq}, 32'h0);
        reg_write(4'd2, 32'h4, 4'hF);
        check("R11 enable pending flag", {31'b0, irq}, 32'h1);
        reg_write(4'd0, 32'h4, 4'hF);
        check("R11 irq low after clears", {31'b0, irq}, 32'h0);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_strobe();
        t_capture();
        t_many();
        t_clear_capture();
        t_mbe_mse();
        t_threshold();
        t_thr_zero();
        t_disable();
        t_w1c();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule